// File: doc/BRIEF.md
# Wake and Fault Interrupt Register

This block is the 32-bit flag register through which a host learns why a bus-interface device woke up or raised a fault. Detectors elsewhere in the device deliver one-cycle event pulses: supply and IO under-voltage, thermal shutdown, watchdog expiry, uncorrectable ECC error, bus wake, local wake, wake error, bus silent, bus stuck dominant and a sleep-entry status. Each pulse sets its own sticky flag. The host clears a flag by writing 1 to its bit.

Several bits are never stored. They are computed from the flags and from live inputs. These are the wake request, the bus error, the voltage/temperature/watchdog summary, the SPI error (the SPI status bits after the mask), the core interrupt and a global error bit. The block also watches the operating mode. The two wake flags clear when the mode moves to normal or to sleep, and the power-on flag clears when the mode leaves standby for either of those two modes.

A bus-normal bit is a plain status flag and raises no interrupt. It shows that the bus has been seen working in normal mode. The register has a single address, so the access port is a write strobe with write data and a continuously driven read value. The port has no handshake and no back-pressure. Every write is taken in the cycle its strobe is high.

Top module: `wake_fault_irq_reg`

## Requirements
- R1: After reset the power-on flag (bit 20) is 1 and every stored flag and the bus-normal bit are 0. With the SPI status, mask and core interrupt inputs at 0, the register reads 0x0010_0000. Bits outside 31, 23:18 except 17, 16:13, 10, 8, 7:5, 3, 1 and 0 always read 0.
- R2: Each event pulse sets its sticky flag, which reads 1 from the next cycle on: sleep status bit 23, supply under-voltage 22, IO under-voltage 21, thermal 19, watchdog 18, ECC 16, wake error 13, bus silent 10, bus dominant 8.
- R3: A write with a 1 in a sticky flag bit (23:18 except 17, 16:13, 10, 8) clears that flag from the next cycle. A 0 leaves it unchanged. Writes to bit 31, to the summary bits and to reserved bits have no effect.
- R4: When an event pulse and a clear of the same flag fall in one cycle, the flag ends up set.
- R5: A bus wake pulse sets bit 15 only while bit 14 is 0. A local wake pulse sets bit 14 only while bit 15 is 0. If both pulses arrive together while both flags are 0, only bit 15 sets. Bits 15 and 14 are never 1 together.
- R6: Mode encoding is 00 standby, 01 normal, 10 sleep, 11 test. When the mode input differs from its value in the previous cycle and is normal or sleep, bits 15 and 14 clear. No other mode change clears them.
- R7: The power-on flag clears on a write of 1 to bit 20, or when the mode moves from standby to normal or from standby to sleep. It is never set again except by reset.
- R8: Bit 31 sets in the cycle after a dominant-to-recessive edge indication arrives while the mode is normal. It reads 0 in the cycle after any cycle whose mode is not normal, or in which a bus silent or bus dominant pulse arrives. A fault pulse outweighs a simultaneous edge.
- R9: Bit 6 is the OR of bits 15, 14 and 13. Bit 5 is the OR of bits 10 and 8. Bit 0 is the OR of bits 22, 21, 19, 18 and 16.
- R10: Bit 3 is 1 exactly when some position of the 15-bit SPI status input has a 1 while the same position of the mask input is 0. It follows the inputs in the same cycle.
- R11: Bit 1 follows the core interrupt input in the same cycle. Bit 7 is the OR of bits 22, 21, 19, 18, 16, 13, 10, 8, 3 and 1. The power-on, sleep status and wake flags do not count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode: 00 standby, 01 normal, 10 sleep, 11 test |
| evt_sleep_stat_i | input | 1 | Pulse: sleep entered due to a fault |
| evt_uv_supply_i | input | 1 | Pulse: supply under-voltage |
| evt_uv_io_i | input | 1 | Pulse: IO supply under-voltage |
| evt_thermal_i | input | 1 | Pulse: thermal shutdown |
| evt_wdog_i | input | 1 | Pulse: watchdog timeout |
| evt_ecc_i | input | 1 | Pulse: uncorrectable ECC error |
| evt_bus_wake_i | input | 1 | Pulse: wake pattern seen on the bus |
| evt_local_wake_i | input | 1 | Pulse: local wake pin toggled |
| evt_wake_err_i | input | 1 | Pulse: wake not serviced in time |
| evt_bus_silent_i | input | 1 | Pulse: bus silent fault |
| evt_bus_dom_i | input | 1 | Pulse: bus stuck dominant fault |
| bus_d2r_i | input | 1 | Pulse: dominant-to-recessive bus edge |
| core_irq_i | input | 1 | Level: protocol core interrupt |
| spi_stat_i | input | 15 | SPI error status bits |
| spi_mask_i | input | 15 | SPI error mask, 1 suppresses the source |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data, 1 clears a sticky flag |
| rd_data_o | output | 32 | Current register value |

## Verification
Single pulses on each event line, one at a time, show that every flag lands on its own bit and that no flag bleeds into another. Write patterns of all ones, all zeros and a single one each separate clearing from ignoring, and events placed in the same cycle as a clear separate set-priority from clear-priority. Wake pulses are sent in both orders and together, with mode walks through standby, normal, sleep and test. These runs tell the lockout apart from the auto-clear and show which mode transitions drop the power-on flag. SPI status and mask combinations with matching and non-matching positions, together with bus edges and faults in and out of normal mode, exercise the summary bits and the bus-normal bit.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'b00,
    MODE_NORMAL  = 2'b01,
    MODE_SLEEP   = 2'b10,
    MODE_TEST    = 2'b11
  } op_mode_e;

  localparam int REG_W  = 32;
  localparam int SPI_W  = 15;
  localparam int NFLAG  = 12;

  // index of each sticky flag in the flag vector
  localparam int F_SMS    = 0;
  localparam int F_UVSUP  = 1;
  localparam int F_UVIO   = 2;
  localparam int F_PWRON  = 3;
  localparam int F_TSD    = 4;
  localparam int F_WDTO   = 5;
  localparam int F_ECC    = 6;
  localparam int F_BWAKE  = 7;
  localparam int F_LWAKE  = 8;
  localparam int F_WKERR  = 9;
  localparam int F_SILENT = 10;
  localparam int F_DOM    = 11;

  // bit position of each flag in the register, indexed as above
  localparam int FLAG_POS [NFLAG] = '{23, 22, 21, 20, 19, 18, 16, 15, 14, 13, 10, 8};

  localparam int B_BUSNOM = 31;
  localparam int B_GLOBAL = 7;
  localparam int B_WKREQ  = 6;
  localparam int B_BUSERR = 5;
  localparam int B_SPIERR = 3;
  localparam int B_CORE   = 1;
  localparam int B_VTW    = 0;
endpackage

// File: rtl/wfi_flag_cell.sv
module wfi_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/wfi_wake_lock.sv
module wfi_wake_lock (
  input  logic bus_ev_i,
  input  logic loc_ev_i,
  input  logic bus_q_i,
  input  logic loc_q_i,
  output logic bus_set_o,
  output logic loc_set_o
);
  // a held flag blocks the other source; a tie goes to the bus source
  always_comb begin
    bus_set_o = bus_ev_i && !loc_q_i;
    loc_set_o = loc_ev_i && !bus_q_i && !bus_set_o;
  end
endmodule

// File: rtl/wfi_bus_nominal.sv
module wfi_bus_nominal (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       edge_i,
  input  logic       fault_i,
  output logic       q_o
);
  import wfi_pkg::*;
  op_mode_e mode;
  assign mode = op_mode_e'(mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                  q_o <= 1'b0;
    else if (mode != MODE_NORMAL) q_o <= 1'b0;
    else if (fault_i)            q_o <= 1'b0;
    else if (edge_i)             q_o <= 1'b1;
  end
endmodule

// File: rtl/wfi_summary.sv
module wfi_summary #(
  parameter int SPI_W = 15
) (
  input  logic             uvsup_i,
  input  logic             uvio_i,
  input  logic             tsd_i,
  input  logic             wdto_i,
  input  logic             ecc_i,
  input  logic             bwake_i,
  input  logic             lwake_i,
  input  logic             wkerr_i,
  input  logic             silent_i,
  input  logic             dom_i,
  input  logic [SPI_W-1:0] spi_stat_i,
  input  logic [SPI_W-1:0] spi_mask_i,
  input  logic             core_i,
  output logic             wkreq_o,
  output logic             buserr_o,
  output logic             spierr_o,
  output logic             vtw_o,
  output logic             global_o
);
  always_comb begin
    wkreq_o  = bwake_i | lwake_i | wkerr_i;
    buserr_o = silent_i | dom_i;
    spierr_o = |(spi_stat_i & ~spi_mask_i);
    vtw_o    = uvsup_i | uvio_i | tsd_i | wdto_i | ecc_i;
    global_o = vtw_o | wkerr_i | buserr_o | spierr_o | core_i;
  end
endmodule

// File: rtl/wake_fault_irq_reg.sv
module wake_fault_irq_reg
  import wfi_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int SPI_BITS = SPI_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                evt_sleep_stat_i,
  input  logic                evt_uv_supply_i,
  input  logic                evt_uv_io_i,
  input  logic                evt_thermal_i,
  input  logic                evt_wdog_i,
  input  logic                evt_ecc_i,
  input  logic                evt_bus_wake_i,
  input  logic                evt_local_wake_i,
  input  logic                evt_wake_err_i,
  input  logic                evt_bus_silent_i,
  input  logic                evt_bus_dom_i,
  input  logic                bus_d2r_i,
  input  logic                core_irq_i,
  input  logic [SPI_BITS-1:0] spi_stat_i,
  input  logic [SPI_BITS-1:0] spi_mask_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o
);
  op_mode_e   mode_now, mode_q;
  logic [NFLAG-1:0] flag_q, set_v, auto_clr;
  logic bus_set, loc_set, mode_chg, wake_clr, pwron_clr;
  logic busnom_q, wkreq, buserr, spierr, vtw, glob;

  assign mode_now = op_mode_e'(mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_STANDBY;
    else        mode_q <= mode_now;
  end

  assign mode_chg  = (mode_now != mode_q);
  assign wake_clr  = mode_chg && (mode_now == MODE_NORMAL || mode_now == MODE_SLEEP);
  assign pwron_clr = (mode_q == MODE_STANDBY) &&
                     (mode_now == MODE_NORMAL || mode_now == MODE_SLEEP);

  wfi_wake_lock u_lock (
    .bus_ev_i (evt_bus_wake_i),
    .loc_ev_i (evt_local_wake_i),
    .bus_q_i  (flag_q[F_BWAKE]),
    .loc_q_i  (flag_q[F_LWAKE]),
    .bus_set_o(bus_set),
    .loc_set_o(loc_set)
  );

  always_comb begin
    set_v           = '0;
    set_v[F_SMS]    = evt_sleep_stat_i;
    set_v[F_UVSUP]  = evt_uv_supply_i;
    set_v[F_UVIO]   = evt_uv_io_i;
    set_v[F_TSD]    = evt_thermal_i;
    set_v[F_WDTO]   = evt_wdog_i;
    set_v[F_ECC]    = evt_ecc_i;
    set_v[F_BWAKE]  = bus_set;
    set_v[F_LWAKE]  = loc_set;
    set_v[F_WKERR]  = evt_wake_err_i;
    set_v[F_SILENT] = evt_bus_silent_i;
    set_v[F_DOM]    = evt_bus_dom_i;
    auto_clr          = '0;
    auto_clr[F_BWAKE] = wake_clr;
    auto_clr[F_LWAKE] = wake_clr;
    auto_clr[F_PWRON] = pwron_clr;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    wfi_flag_cell #(.RST_VAL((g == F_PWRON) ? 1'b1 : 1'b0)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_v[g]),
      .clr_i((wr_en_i && wr_data_i[FLAG_POS[g]]) || auto_clr[g]),
      .q_o  (flag_q[g])
    );
  end

  wfi_bus_nominal u_busnom (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .edge_i (bus_d2r_i),
    .fault_i(evt_bus_silent_i || evt_bus_dom_i),
    .q_o    (busnom_q)
  );

  wfi_summary #(.SPI_W(SPI_BITS)) u_sum (
    .uvsup_i   (flag_q[F_UVSUP]),
    .uvio_i    (flag_q[F_UVIO]),
    .tsd_i     (flag_q[F_TSD]),
    .wdto_i    (flag_q[F_WDTO]),
    .ecc_i     (flag_q[F_ECC]),
    .bwake_i   (flag_q[F_BWAKE]),
    .lwake_i   (flag_q[F_LWAKE]),
    .wkerr_i   (flag_q[F_WKERR]),
    .silent_i  (flag_q[F_SILENT]),
    .dom_i     (flag_q[F_DOM]),
    .spi_stat_i(spi_stat_i),
    .spi_mask_i(spi_mask_i),
    .core_i    (core_irq_i),
    .wkreq_o   (wkreq),
    .buserr_o  (buserr),
    .spierr_o  (spierr),
    .vtw_o     (vtw),
    .global_o  (glob)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NFLAG; i++) rd_data_o[FLAG_POS[i]] = flag_q[i];
    rd_data_o[B_BUSNOM] = busnom_q;
    rd_data_o[B_GLOBAL] = glob;
    rd_data_o[B_WKREQ]  = wkreq;
    rd_data_o[B_BUSERR] = buserr;
    rd_data_o[B_SPIERR] = spierr;
    rd_data_o[B_CORE]   = core_irq_i;
    rd_data_o[B_VTW]    = vtw;
  end
endmodule

// File: rtl/wake_fault_irq_reg_chk.sv
module wake_fault_irq_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode_i,
  input logic [1:0]  mode_q,
  input logic        evt_uv_supply_i,
  input logic        evt_bus_wake_i,
  input logic        evt_local_wake_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o
);
  localparam logic [31:0] USED = 32'h80FD_E5EB;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~USED) == 32'h0);

  a_r2_uvsup_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_uv_supply_i |=> rd_data_o[22]);

  a_r3_uvsup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[22] && !evt_uv_supply_i) |=> !rd_data_o[22]);

  a_r5_wake_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data_o[15] && rd_data_o[14]));

  a_r6_wake_clear_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && mode_q != 2'b01 && !evt_bus_wake_i && !evt_local_wake_i)
      |=> (!rd_data_o[15] && !rd_data_o[14]));

  a_r7_pwron_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data_o[20] |=> !rd_data_o[20]);

  a_r8_busnom_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b01) |=> !rd_data_o[31]);
endmodule

bind wake_fault_irq_reg wake_fault_irq_reg_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_i          (mode_i),
  .mode_q          (mode_q),
  .evt_uv_supply_i (evt_uv_supply_i),
  .evt_bus_wake_i  (evt_bus_wake_i),
  .evt_local_wake_i(evt_local_wake_i),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .rd_data_o       (rd_data_o)
);

// File: tb/wake_fault_irq_reg_bench.sv
module wake_fault_irq_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic e_sms = 0, e_uvs = 0, e_uvi = 0, e_tsd = 0, e_wd = 0, e_ecc = 0;
  logic e_bw = 0, e_lw = 0, e_we = 0, e_sil = 0, e_dom = 0, d2r = 0, core = 0;
  logic [14:0] sstat = '0, smask = '0;
  logic wr = 0;
  logic [31:0] wdat = '0;
  logic [31:0] rd;

  int checks = 0, fails = 0;
  logic [31:0] mf;
  logic mbn;
  logic [1:0] mq;

  always #5 clk = ~clk;

  wake_fault_irq_reg u_wake_fault_irq_reg (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .evt_sleep_stat_i(e_sms), .evt_uv_supply_i(e_uvs), .evt_uv_io_i(e_uvi),
    .evt_thermal_i(e_tsd), .evt_wdog_i(e_wd), .evt_ecc_i(e_ecc),
    .evt_bus_wake_i(e_bw), .evt_local_wake_i(e_lw), .evt_wake_err_i(e_we),
    .evt_bus_silent_i(e_sil), .evt_bus_dom_i(e_dom), .bus_d2r_i(d2r),
    .core_irq_i(core), .spi_stat_i(sstat), .spi_mask_i(smask),
    .wr_en_i(wr), .wr_data_i(wdat), .rd_data_o(rd));

  // reference model, updated at each rising edge
  always @(posedge clk) begin
    logic [31:0] st, cl;
    if (!rst_n) begin
      mf = 32'h0010_0000; mbn = 0; mq = 2'b00;
    end else begin
      st = 0; cl = 0;
      if (wr) cl = wdat & 32'h00FD_E500;
      if (mode != mq && (mode == 2'b01 || mode == 2'b10)) cl = cl | 32'h0000_C000;
      if (mq == 2'b00 && (mode == 2'b01 || mode == 2'b10)) cl[20] = 1;
      st[23] = e_sms; st[22] = e_uvs; st[21] = e_uvi; st[19] = e_tsd;
      st[18] = e_wd; st[16] = e_ecc; st[13] = e_we; st[10] = e_sil; st[8] = e_dom;
      if (e_bw && !mf[14]) st[15] = 1;
      if (e_lw && !mf[15] && !st[15]) st[14] = 1;
      if (mode != 2'b01 || e_sil || e_dom) mbn = 0;
      else if (d2r) mbn = 1;
      mf = (mf & ~cl) | st;
      mq = mode;
    end
  end

  function automatic logic [31:0] model_read();
    logic [31:0] r;
    logic spi, v, be;
    r = mf;
    r[31] = mbn;
    spi = |(sstat & ~smask);
    v = mf[22] | mf[21] | mf[19] | mf[18] | mf[16];
    be = mf[10] | mf[8];
    r[0] = v; r[1] = core; r[3] = spi; r[5] = be;
    r[6] = mf[15] | mf[14] | mf[13];
    r[7] = v | mf[13] | be | spi | core;
    return r;
  endfunction

  function automatic string req_of(int b);
    case (b)
      31: return "R8";
      20: return "R7";
      15, 14: return "R5/R6";
      7, 1: return "R11";
      3: return "R10";
      6, 5, 0: return "R9";
      23, 22, 21, 19, 18, 16, 13, 10, 8: return "R2/R3/R4";
      default: return "R1";
    endcase
  endfunction

  // per-cycle comparison against the model, after the falling edge
  task automatic tick();
    logic [31:0] e;
    @(posedge clk); @(negedge clk);
    if (rst_n) begin
      e = model_read();
      checks++;
      if (rd !== e) begin
        fails++;
        for (int b = 0; b < 32; b++)
          if (rd[b] !== e[b])
            $display("FAIL %s bit %0d actual %b expected %b (reg %h vs %h)",
                     req_of(b), b, rd[b], e[b], rd, e);
      end
    end
  endtask

  task automatic expect_bits(input logic [31:0] m, input logic [31:0] v, input string tag);
    checks++;
    if ((rd & m) !== (v & m)) begin
      fails++;
      $display("FAIL %s actual %h expected %h (mask %h)", tag, rd & m, v & m, m);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; mode = 2'b00; tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic wr1(input logic [31:0] d);
    wr = 1; wdat = d; tick(); wr = 0; wdat = '0;
  endtask

  initial begin
    #(10 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    expect_bits(32'hFFFF_FFFF, 32'h0010_0000, "R1 reset value");

    // R2: single events
    e_uvs = 1; tick(); e_uvs = 0; expect_bits(32'h0040_0001, 32'h0040_0001, "R2 uvsup + R9 vtw");
    e_tsd = 1; tick(); e_tsd = 0; expect_bits(32'h0008_0000, 32'h0008_0000, "R2 thermal");
    e_sms = 1; tick(); e_sms = 0; e_we = 1; tick(); e_we = 0;
    expect_bits(32'h0080_2040, 32'h0080_2040, "R2 sms, wkerr, R9 wake req");
    e_sil = 1; tick(); e_sil = 0; expect_bits(32'h0000_0420, 32'h0000_0420, "R2 silent + R9 bus err");
    e_uvi = 1; e_wd = 1; e_ecc = 1; e_dom = 1; tick();
    e_uvi = 0; e_wd = 0; e_ecc = 0; e_dom = 0;

    // R3: zero write, all-ones write, single bit clear
    wr1(32'h0000_0000); expect_bits(32'h00FD_E500, 32'h00FD_2500, "R3 zero write no effect");
    wr1(32'h0040_0000); expect_bits(32'h0040_0000, 32'h0, "R3 single clear");
    core = 1; sstat = 15'h0001;
    wr1(32'hFFFF_FFFF);
    expect_bits(32'hFFFF_FFFF, 32'h0000_008A, "R3 all-ones clears flags, summaries kept");
    // R10 mask
    smask = 15'h0001; tick(); expect_bits(32'h0000_0008, 32'h0, "R10 masked source");
    sstat = 15'h4002; tick(); expect_bits(32'h0000_0008, 32'h8, "R10 unmasked source");
    core = 0; sstat = 0; smask = 0; tick();
    expect_bits(32'h0000_008B, 32'h0, "R11 global drops");

    // R4: set wins over clear
    e_tsd = 1; wr = 1; wdat = 32'h0008_0000; tick(); e_tsd = 0; wr = 0; wdat = 0;
    expect_bits(32'h0008_0000, 32'h0008_0000, "R4 set beats write clear");
    expect_bits(32'h0000_0080, 32'h80, "R11 global from thermal");
    wr1(32'h0008_0000);

    // R5 lockout, R6 auto clear
    e_bw = 1; tick(); e_bw = 0; e_lw = 1; tick(); e_lw = 0;
    expect_bits(32'h0000_C000, 32'h0000_8000, "R5 local ignored while bus wake set");
    mode = 2'b11; tick(); expect_bits(32'h0000_C000, 32'h0000_8000, "R6 test mode keeps wake");
    mode = 2'b01; tick(); expect_bits(32'h0000_C000, 32'h0, "R6 normal clears wake");
    e_lw = 1; tick(); e_lw = 0; e_bw = 1; tick(); e_bw = 0;
    expect_bits(32'h0000_C000, 32'h0000_4000, "R5 bus ignored while local set");
    tick(); expect_bits(32'h0000_4000, 32'h0000_4000, "R6 no repeat clear");
    mode = 2'b10; tick(); expect_bits(32'h0000_C000, 32'h0, "R6 sleep clears wake");
    e_bw = 1; e_lw = 1; tick(); e_bw = 0; e_lw = 0;
    expect_bits(32'h0000_C000, 32'h0000_8000, "R5 tie goes to bus wake");

    // R7 power-on
    do_reset(); mode = 2'b10; tick(); expect_bits(32'h0010_0000, 32'h0, "R7 standby to sleep clears");
    do_reset(); mode = 2'b01; tick(); expect_bits(32'h0010_0000, 32'h0, "R7 standby to normal clears");
    do_reset(); mode = 2'b11; tick(); mode = 2'b01; tick();
    expect_bits(32'h0010_0000, 32'h0010_0000, "R7 test to normal keeps");
    wr1(32'h0010_0000); expect_bits(32'h0010_0000, 32'h0, "R7 write clears");

    // R8 bus normal
    d2r = 1; tick(); d2r = 0; expect_bits(32'h8000_0000, 32'h8000_0000, "R8 set on edge in normal");
    wr1(32'h8000_0000); expect_bits(32'h8000_0000, 32'h8000_0000, "R3 bus normal write ignored");
    e_dom = 1; d2r = 1; tick(); e_dom = 0; d2r = 0;
    expect_bits(32'h8000_0000, 32'h0, "R8 fault beats edge");
    d2r = 1; tick(); d2r = 0; mode = 2'b00; tick();
    expect_bits(32'h8000_0000, 32'h0, "R8 leaving normal clears");
    d2r = 1; tick(); d2r = 0; expect_bits(32'h8000_0000, 32'h0, "R8 edge outside normal ignored");
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule